// File: doc/BRIEF.md
# ADC conversion trigger selector

This block decides when the analog-to-digital converter of a multichannel acquisition front end begins a conversion. It has three trigger sources: a software strobe, a fixed-rate pacer built from two cascaded down-counters, and an external trigger input that is synchronised inside the block. Software picks one of them with two mode bits. The external-select bit overrides everything else: while it is set, the software strobe and the pacer cannot start a conversion. The block also holds the gain code that the analog path uses. One gain applies to all channels, and the input is bipolar only, so the gain register has no polarity field.

Software reaches the block through a simple write port made of an enable, a 3-bit address and a data word. The block produces a conversion-start pulse one clock wide and drives the gain code continuously. If a trigger arrives while the converter reports busy, the block drops that trigger and sets a sticky overrun flag. Software clears the flag by writing to its address.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset, `conv_start` is 0, `gain_code` is 0, `overrun` is 0, and the trigger mode is software (both mode bits 0).
- R2: The mode register is at address 0. Bit 0 selects the external source and bit 1 selects the pacer. With both bits at 0, a write of any data value to address 3 raises `conv_start` for exactly one clock, on the edge that takes the write.
- R3: While mode bit 0 is 1, writes to address 3 produce no start pulse, whatever the value of bit 1, and the pacer produces none either. External edges still start conversions.
- R4: With mode bit 0 at 1, each rising edge of `ext_trig` gives exactly one start pulse, however long the input then stays high. The pulse appears on the third clock edge after the input rises. While mode bit 0 is 0, `ext_trig` has no effect.
- R5: With mode bits 0 and 1 set to 0 and 1, conversions start with a period equal to the product of the two divisors, which are written at address 1 (first counter) and address 2 (second counter). The first pulse appears one full period after the clock edge that takes the mode write.
- R6: A divisor value below 2 is used as 2.
- R7: In pacer mode, writing either divisor restarts the pacer. The next pulse appears one period plus one clock after the clock edge that takes the write.
- R8: Outside pacer mode the pacer counters stay at their reload values, so each entry into pacer mode begins a full period. In pacer mode, writes to address 3 produce no pulse.
- R9: A write to address 4 stores data bits 2:0 as the gain code if that value is 0 to 4, which selects gain 1, 2, 4, 8 or 16. The values 5 to 7 are ignored and the previous code is kept.
- R10: A trigger from the selected source that arrives while `conv_busy` is high produces no pulse and sets `overrun`. `overrun` stays set until a write to address 5, which clears it on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DIV_W (16) | Write data |
| ext_trig | input | 1 | External trigger, asynchronous to `clk` |
| conv_busy | input | 1 | Converter busy |
| conv_start | output | 1 | Conversion start pulse |
| gain_code | output | 3 | Current gain code |
| overrun | output | 1 | Sticky flag for a dropped trigger |

## Verification
Each result has its own delay. A software strobe, a gain write and an overrun set or clear all show on the write edge itself. An external rise reaches `conv_start` on the third edge after the input changes. A pacer pulse comes one period after the mode write, or one period plus one edge after a divisor write. The bench drives inputs on falling edges and samples one nanosecond after the rising edge. A falling-edge monitor records the index of the edge that produced each pulse, so every check compares an exact edge number against these delays instead of waiting loosely.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int ADDR_W        = 3;
    localparam int GAIN_W        = 3;
    localparam int PACER_STAGES  = 2;
    localparam logic [GAIN_W-1:0] GAIN_MAX_CODE = 3'd4;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_DIV0   = 3'd1,
        A_DIV1   = 3'd2,
        A_SWTRIG = 3'd3,
        A_GAIN   = 3'd4,
        A_CLROVR = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic pacer_sel;
        logic ext_sel;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2
    } trig_src_e;

    function automatic trig_src_e decode_mode(mode_t m);
        if (m.ext_sel)
            return SRC_EXT;
        else if (m.pacer_sel)
            return SRC_PACER;
        else
            return SRC_SOFT;
    endfunction

    function automatic logic gain_code_ok(logic [GAIN_W-1:0] c);
        return c <= GAIN_MAX_CODE;
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/trig_pacer.sv
module trig_pacer #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       restart,
    input  logic [STAGES-1:0][W-1:0]   div_vals,
    output logic                       tick
);
    logic [STAGES:0] carry;

    assign carry[0] = run & ~restart;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] cnt;
        logic [W-1:0] reload;

        assign reload = div_vals[g] - W'(1);

        always_ff @(posedge clk) begin
            if (rst || !run || restart)
                cnt <= reload;
            else if (carry[g])
                cnt <= (cnt == '0) ? reload : cnt - W'(1);
        end

        assign carry[g+1] = carry[g] & (cnt == '0);
    end

    assign tick = carry[STAGES];
endmodule

// File: rtl/trig_start_gate.sv
module trig_start_gate
    import adc_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_src_e src,
    input  logic      soft_req,
    input  logic      pacer_tick,
    input  logic      ext_rise,
    input  logic      busy,
    input  logic      clr_ovr,
    output logic      conv_start,
    output logic      overrun
);
    logic trig;

    always_comb begin
        case (src)
            SRC_SOFT:  trig = soft_req;
            SRC_PACER: trig = pacer_tick;
            SRC_EXT:   trig = ext_rise;
            default:   trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            conv_start <= trig & ~busy;
            if (trig && busy)
                overrun <= 1'b1;
            else if (clr_ovr)
                overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    input  logic              ext_trig,
    input  logic              conv_busy,
    output logic              conv_start,
    output logic [GAIN_W-1:0] gain_code,
    output logic              overrun
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    function automatic logic [DIV_W-1:0] clamp_div(logic [DIV_W-1:0] v);
        return (v < DIV_MIN) ? DIV_MIN : v;
    endfunction

    mode_t                               mode_q;
    logic [GAIN_W-1:0]                   gain_q;
    logic [PACER_STAGES-1:0][DIV_W-1:0]  div_q;
    logic                                restart_q;
    logic [PACER_STAGES-1:0]             wr_div;
    logic                                wr_mode, wr_soft, wr_gain, wr_clr;
    trig_src_e                           src;
    logic                                pacer_tick, ext_rise;

    assign wr_mode = wr_en && (wr_addr == A_MODE);
    assign wr_soft = wr_en && (wr_addr == A_SWTRIG);
    assign wr_gain = wr_en && (wr_addr == A_GAIN);
    assign wr_clr  = wr_en && (wr_addr == A_CLROVR);
    assign wr_div[0] = wr_en && (wr_addr == A_DIV0);
    assign wr_div[1] = wr_en && (wr_addr == A_DIV1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            gain_q    <= '0;
            restart_q <= 1'b0;
            for (int i = 0; i < PACER_STAGES; i++)
                div_q[i] <= DIV_MIN;
        end else begin
            if (wr_mode)
                mode_q <= mode_t'(wr_data[1:0]);
            if (wr_gain && gain_code_ok(wr_data[GAIN_W-1:0]))
                gain_q <= wr_data[GAIN_W-1:0];
            restart_q <= |wr_div;
            for (int i = 0; i < PACER_STAGES; i++)
                if (wr_div[i])
                    div_q[i] <= clamp_div(wr_data);
        end
    end

    assign src       = decode_mode(mode_q);
    assign gain_code = gain_q;

    trig_pacer #(
        .W      (DIV_W),
        .STAGES (PACER_STAGES)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .run      (src == SRC_PACER),
        .restart  (restart_q),
        .div_vals (div_q),
        .tick     (pacer_tick)
    );

    trig_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ext (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_trig),
        .rise (ext_rise)
    );

    trig_start_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .soft_req   (wr_soft),
        .pacer_tick (pacer_tick),
        .ext_rise   (ext_rise),
        .busy       (conv_busy),
        .clr_ovr    (wr_clr),
        .conv_start (conv_start),
        .overrun    (overrun)
    );
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk
    import adc_trig_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DIV_W-1:0]  wr_data,
    input logic              conv_busy,
    input logic              conv_start,
    input logic [GAIN_W-1:0] gain_code,
    input logic              overrun,
    input trig_src_e         src
);
    p_soft_start_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_SWTRIG && src == SRC_SOFT && !conv_busy) |=> conv_start);

    p_gain_legal_r9: assert property (@(posedge clk) disable iff (rst)
        gain_code <= GAIN_MAX_CODE);

    p_gain_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_GAIN && wr_data[GAIN_W-1:0] > GAIN_MAX_CODE) |=> $stable(gain_code));

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        conv_busy |=> !conv_start);

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (overrun && !(wr_en && wr_addr == A_CLROVR)) |=> overrun);
endmodule

bind adc_trig_sel adc_trig_sel_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .conv_busy  (conv_busy),
    .conv_start (conv_start),
    .gain_code  (gain_code),
    .overrun    (overrun),
    .src        (src)
);

// File: tb/sim_adc_trig_sel.sv
`timescale 1ns/1ps
module sim_adc_trig_sel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ext_trig = 1'b0;
    logic        conv_busy = 1'b0;
    logic        conv_start;
    logic [2:0]  gain_code;
    logic        overrun;

    int cyc = 0;
    int pulses = 0;
    int last_pc = -1;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    adc_trig_sel u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_trig(ext_trig), .conv_busy(conv_busy), .conv_start(conv_start),
        .gain_code(gain_code), .overrun(overrun)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (conv_start === 1'b1) begin
            pulses  = pulses + 1;
            last_pc = cyc;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_pulse(int target, int limit);
        for (int k = 0; k < limit && pulses < target; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(1);
        chk("R1", "conv_start", int'(conv_start), 0);
        chk("R1", "gain_code", int'(gain_code), 0);
        chk("R1", "overrun", int'(overrun), 0);
    endtask

    task automatic t_soft;
        int base;
        wr(3'd3, 16'hBEEF);
        chk("R2", "pulse on write edge", int'(conv_start), 1);
        idle(1);
        chk("R2", "pulse one clock wide", int'(conv_start), 0);
        base = pulses;
        wr(3'd3, 16'h0000);
        idle(2);
        chk("R2", "one pulse for zero data", pulses - base, 1);
    endtask

    task automatic t_gain;
        wr(3'd4, 16'd3);
        chk("R9", "gain 3 stored", int'(gain_code), 3);
        wr(3'd4, 16'd6);
        chk("R9", "code 6 ignored", int'(gain_code), 3);
        wr(3'd4, 16'd4);
        chk("R9", "gain 4 stored", int'(gain_code), 4);
        wr(3'd4, 16'd5);
        chk("R9", "code 5 ignored", int'(gain_code), 4);
        wr(3'd4, 16'd0);
        chk("R9", "gain 0 stored", int'(gain_code), 0);
    endtask

    task automatic t_busy;
        int base;
        base = pulses;
        @(negedge clk) conv_busy = 1'b1;
        wr(3'd3, 16'd1);
        chk("R10", "no pulse while busy", int'(conv_start), 0);
        chk("R10", "overrun set", int'(overrun), 1);
        @(negedge clk) conv_busy = 1'b0;
        wr(3'd4, 16'd1);
        idle(3);
        chk("R10", "overrun sticky", int'(overrun), 1);
        chk("R10", "dropped trigger gave no pulse", pulses - base, 0);
        wr(3'd5, 16'd0);
        chk("R10", "overrun cleared", int'(overrun), 0);
    endtask

    task automatic t_ext;
        int base, c;
        wr(3'd0, 16'd1);
        base = pulses;
        @(negedge clk);
        c = cyc;
        ext_trig = 1'b1;
        idle(12);
        chk("R4", "one pulse per held edge", pulses - base, 1);
        chk("R4", "pulse edge index", last_pc, c + 3);
        @(negedge clk) ext_trig = 1'b0;
        idle(5);
        @(negedge clk) ext_trig = 1'b1;
        idle(6);
        chk("R4", "second edge second pulse", pulses - base, 2);
        @(negedge clk) ext_trig = 1'b0;
        wr(3'd0, 16'd0);
        idle(4);
        base = pulses;
        @(negedge clk) ext_trig = 1'b1;
        idle(6);
        @(negedge clk) ext_trig = 1'b0;
        idle(6);
        chk("R4", "ext ignored in internal mode", pulses - base, 0);
    endtask

    task automatic t_override;
        int base;
        wr(3'd1, 16'd2);
        wr(3'd2, 16'd2);
        wr(3'd0, 16'd3);
        base = pulses;
        wr(3'd3, 16'd7);
        wr(3'd3, 16'd8);
        idle(30);
        chk("R3", "soft and pacer blocked", pulses - base, 0);
        @(negedge clk) ext_trig = 1'b1;
        idle(6);
        chk("R3", "ext works with pacer bit set", pulses - base, 1);
        @(negedge clk) ext_trig = 1'b0;
        wr(3'd0, 16'd0);
        idle(3);
    endtask

    task automatic t_pacer;
        int base, k, p1;
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd5);
        wr(3'd0, 16'd2);
        k = cyc;
        base = pulses;
        wait_pulse(base + 1, 100);
        chk("R5", "first pulse after one period", last_pc, k + 15);
        p1 = last_pc;
        wait_pulse(base + 2, 100);
        chk("R5", "period is product", last_pc - p1, 15);
        base = pulses;
        wr(3'd3, 16'd9);
        idle(3);
        chk("R8", "soft write ignored in pacer mode", pulses - base, 0);
        wr(3'd0, 16'd0);
        idle(37);
        wr(3'd0, 16'd2);
        k = cyc;
        base = pulses;
        wait_pulse(base + 1, 100);
        chk("R8", "counters held then full period", last_pc, k + 15);
    endtask

    task automatic t_restart;
        int base, w;
        wr(3'd2, 16'd2);
        w = cyc;
        base = pulses;
        wait_pulse(base + 1, 100);
        if (last_pc == w)
            wait_pulse(base + 2, 100);
        chk("R7", "restart pulse at period plus one", last_pc, w + 7);
        wr(3'd0, 16'd0);
        idle(3);
    endtask

    task automatic t_clamp;
        int base, k, p1;
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd1);
        wr(3'd0, 16'd2);
        k = cyc;
        base = pulses;
        wait_pulse(base + 1, 100);
        chk("R6", "clamped first pulse", last_pc, k + 4);
        p1 = last_pc;
        wait_pulse(base + 2, 100);
        chk("R6", "clamped period 4", last_pc - p1, 4);
        wr(3'd0, 16'd0);
        idle(3);
    endtask

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_soft();
        t_gain();
        t_busy();
        t_ext();
        t_override();
        t_pacer();
        t_restart();
        t_clamp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule